// File: doc/BRIEF.md
# Watchdog Timer with Shared Prescaler

The block is a watchdog that advances on a clock enable of its own, `wdt_tick`, which keeps pulsing while the core sleeps. An expiry asks for one of two things. If the core is awake, it requests a device reset. If `sleep_mode` is set, it requests a wake-up so execution can carry on. The status flag `timeout_n` falls to 0 on every expiry. Software restarts the count with a clear strobe or a sleep strobe.

A single 8-bit power-of-two prescaler is shared by the watchdog and a general-purpose timer, and one routing bit decides which of the two it serves. The other path then runs undivided. The 3-bit ratio field picks one of eight prescaler taps, giving 1:1 up to 1:128. The two strobes clear the prescaler only while it belongs to the watchdog.

Top module: `wdt_shared_presc`

## Requirements
- R1: While `sleep_mode` is 0, `reset_req` pulses high for exactly one cycle after the watchdog has seen PERIOD (default 18) counted steps since the last clear, and `wake_req` stays 0.
- R2: While `sleep_mode` is 1, the same expiry pulses `wake_req` for one cycle instead of `reset_req`, and `wdt_tick` keeps counting during that time.
- R3: While `wdt_en` is 0, no `wdt_tick` advances the watchdog or the prescaler. No request is raised, and `timeout_n` keeps its value.
- R4: With `psc_to_wdt` = 1, the watchdog counts prescaled ticks and `tmr_tick` follows `tmr_src_tick` one cycle later, undivided. With `psc_to_wdt` = 0, the watchdog counts every `wdt_tick` and `tmr_tick` carries the prescaled `tmr_src_tick`.
- R5: A ratio value r (0 to 7, unsigned) divides the path that owns the prescaler by 2^r. The first output comes on the 2^r-th input tick after a prescaler clear, and one follows every 2^r ticks after that.
- R6: A high `clear_stb` or `sleep_stb` zeroes the watchdog count. It also zeroes the prescaler, but only while `psc_to_wdt` is 1.
- R7: After an expiry the count restarts from zero, so the next expiry comes PERIOD·2^r input ticks later.
- R8: `timeout_n` is 1 out of reset. It goes to 0 on the cycle an expiry request appears and returns to 1 after either strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-running fabric clock |
| rst_n | input | 1 | Active-low power-on reset |
| wdt_tick | input | 1 | Enable from the independent watchdog oscillator |
| tmr_src_tick | input | 1 | Clock-source enable of the general-purpose timer |
| clear_stb | input | 1 | Watchdog clear strobe |
| sleep_stb | input | 1 | Sleep-entry strobe, clears like `clear_stb` |
| sleep_mode | input | 1 | Core is asleep |
| wdt_en | input | 1 | Permanent watchdog enable |
| psc_to_wdt | input | 1 | 1: prescaler serves watchdog; 0: serves timer |
| ratio | input | 3 | Prescaler tap select, divide by 2^ratio |
| reset_req | output | 1 | One-cycle device reset request |
| wake_req | output | 1 | One-cycle wake-up request |
| timeout_n | output | 1 | Time-out status, 0 after expiry |
| tmr_tick | output | 1 | Tick toward the general-purpose timer |

## Verification
Every result is registered once. `reset_req`, `wake_req`, `timeout_n` and `tmr_tick` change on the clock edge that accepts the qualifying tick or strobe. The bench therefore drives each stimulus for one cycle and reads the outputs at the next falling edge, which is one edge after the stimulus. For expiry, the bench counts requests over the first PERIOD·2^r − 1 ticks and expects none. It then expects the pulse exactly on the following tick and expects it to be gone one cycle later. Timer taps are checked on every input tick against `i mod 2^r = 2^r − 1`.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
   typedef struct packed {
      logic rst;
      logic wake;
   } wdt_req_t;
endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
   parameter int PSC_W = 8,
   parameter int SEL_W = $clog2(PSC_W)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_tick,
   input  logic             clr,
   input  logic [SEL_W-1:0] sel,
   output logic             out_tick
);
   logic [PSC_W-1:0] cnt;
   logic [PSC_W-1:0] tap;

   if (PSC_W != (1 << SEL_W)) begin : g_bad_width
      $error("wdt_prescaler: PSC_W must equal 2**SEL_W");
   end

   for (genvar i = 0; i < PSC_W; i++) begin : g_tap
      if (i == 0) begin : g_first
         assign tap[i] = 1'b1;
      end else begin : g_rest
         assign tap[i] = &cnt[i-1:0];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)       cnt <= '0;
      else if (clr)     cnt <= '0;
      else if (in_tick) cnt <= cnt + 1'b1;
   end

   assign out_tick = in_tick & ~clr & tap[sel];

   assert_psc_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (cnt == '0));
   assert_psc_out_needs_in_R5: assert property (@(posedge clk) disable iff (!rst_n)
      out_tick |-> in_tick);
endmodule

// File: rtl/wdt_core.sv
module wdt_core #(
   parameter int PERIOD = 18,
   parameter int CNT_W  = $clog2(PERIOD)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic tick,
   input  logic clr,
   output logic expire
);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD - 1);

   logic [CNT_W-1:0] cnt;

   if (PERIOD < 2) begin : g_bad_period
      $error("wdt_core: PERIOD must be at least 2");
   end

   always_ff @(posedge clk) begin
      if (!rst_n)          cnt <= '0;
      else if (clr)        cnt <= '0;
      else if (en && tick) cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
   end

   assign expire = en & tick & ~clr & (cnt == LAST);

   assert_cnt_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (cnt == '0));
   assert_hold_disabled_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!en && !clr) |=> $stable(cnt));
   assert_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
      expire |=> (cnt == '0));
   assert_in_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= LAST);
endmodule

// File: rtl/wdt_shared_presc.sv
module wdt_shared_presc #(
   parameter int PSC_W        = 8,
   parameter int PERIOD       = 18,
   parameter bit REG_TMR_TICK = 1'b1,
   localparam int SEL_W       = $clog2(PSC_W),
   localparam int CNT_W       = $clog2(PERIOD)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wdt_tick,
   input  logic             tmr_src_tick,
   input  logic             clear_stb,
   input  logic             sleep_stb,
   input  logic             sleep_mode,
   input  logic             wdt_en,
   input  logic             psc_to_wdt,
   input  logic [SEL_W-1:0] ratio,
   output logic             reset_req,
   output logic             wake_req,
   output logic             timeout_n,
   output logic             tmr_tick
);
   import wdt_pkg::*;

   logic     strobe;
   logic     wdt_src;
   logic     psc_in;
   logic     psc_out;
   logic     wdt_step;
   logic     tmr_next;
   logic     expire;
   wdt_req_t req_q;

   assign strobe   = clear_stb | sleep_stb;
   assign wdt_src  = wdt_tick & wdt_en;
   assign psc_in   = psc_to_wdt ? wdt_src : tmr_src_tick;
   assign wdt_step = psc_to_wdt ? psc_out : wdt_src;
   assign tmr_next = psc_to_wdt ? tmr_src_tick : psc_out;

   wdt_prescaler #(.PSC_W(PSC_W), .SEL_W(SEL_W)) u_psc (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_tick  (psc_in),
      .clr      (strobe & psc_to_wdt),
      .sel      (ratio),
      .out_tick (psc_out)
   );

   wdt_core #(.PERIOD(PERIOD), .CNT_W(CNT_W)) u_core (
      .clk    (clk),
      .rst_n  (rst_n),
      .en     (wdt_en),
      .tick   (wdt_step),
      .clr    (strobe),
      .expire (expire)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         req_q     <= '0;
         timeout_n <= 1'b1;
      end else begin
         req_q.rst  <= expire & ~sleep_mode;
         req_q.wake <= expire & sleep_mode;
         if (strobe)      timeout_n <= 1'b1;
         else if (expire) timeout_n <= 1'b0;
      end
   end

   assign reset_req = req_q.rst;
   assign wake_req  = req_q.wake;

   if (REG_TMR_TICK) begin : g_tmr_reg
      always_ff @(posedge clk) begin
         if (!rst_n) tmr_tick <= 1'b0;
         else        tmr_tick <= tmr_next;
      end
   end else begin : g_tmr_comb
      assign tmr_tick = tmr_next;
   end

   assert_reset_awake_R1: assert property (@(posedge clk) disable iff (!rst_n)
      reset_req |-> !$past(sleep_mode));
   assert_single_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
      reset_req |=> !reset_req);
   assert_wake_asleep_R2: assert property (@(posedge clk) disable iff (!rst_n)
      wake_req |-> $past(sleep_mode));
   assert_exclusive_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({reset_req, wake_req}) <= 1);
   assert_quiet_disabled_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(wdt_en) |-> !(reset_req || wake_req));
   assert_flag_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (reset_req || wake_req) |-> !timeout_n);
   assert_flag_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $past(clear_stb || sleep_stb) |-> timeout_n);
endmodule

// File: tb/wdt_shared_presc_bench.sv
module wdt_shared_presc_bench;
   localparam int CLK_PERIOD = 10;
   localparam int P          = 18;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wdt_tick = 1'b0, tmr_src_tick = 1'b0;
   logic       clear_stb = 1'b0, sleep_stb = 1'b0, sleep_mode = 1'b0;
   logic       wdt_en = 1'b1, psc_to_wdt = 1'b1;
   logic [2:0] ratio = 3'd0;
   logic       reset_req, wake_req, timeout_n, tmr_tick;

   int total = 0, failed = 0;
   int nrst = 0, nwake = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   wdt_shared_presc #(.PSC_W(8), .PERIOD(P)) u_wdt_shared_presc (
      .clk(clk), .rst_n(rst_n), .wdt_tick(wdt_tick), .tmr_src_tick(tmr_src_tick),
      .clear_stb(clear_stb), .sleep_stb(sleep_stb), .sleep_mode(sleep_mode),
      .wdt_en(wdt_en), .psc_to_wdt(psc_to_wdt), .ratio(ratio),
      .reset_req(reset_req), .wake_req(wake_req), .timeout_n(timeout_n),
      .tmr_tick(tmr_tick)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         failed++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("%0d/%0d checks passed", total - failed, total);
      $finish;
   endtask

   task automatic wt(input int n);
      for (int i = 0; i < n; i++) begin
         wdt_tick = 1'b1;
         @(negedge clk);
         wdt_tick = 1'b0;
         nrst  += int'(reset_req);
         nwake += int'(wake_req);
      end
   endtask

   task automatic strobe(input bit slp);
      if (slp) sleep_stb = 1'b1; else clear_stb = 1'b1;
      @(negedge clk);
      sleep_stb = 1'b0;
      clear_stb = 1'b0;
      nrst = 0;
      nwake = 0;
   endtask

   task automatic ttick(input bit v);
      tmr_src_tick = v;
      @(negedge clk);
      tmr_src_tick = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      total++;
      failed++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(timeout_n == 1'b1, "R8 reset flag", timeout_n, 1);
      check(reset_req == 1'b0, "R1 reset idle", reset_req, 0);
      check(wake_req == 1'b0, "R2 reset idle", wake_req, 0);
      check(tmr_tick == 1'b0, "R4 reset idle", tmr_tick, 0);

      // R5 / R1 / R7 / R8: sweep every ratio on the watchdog path
      for (int r = 0; r < 8; r++) begin
         int n;
         n = P << r;
         ratio = 3'(r);
         strobe(1'b0);
         check(timeout_n == 1'b1, "R8 strobe sets flag", timeout_n, 1);
         wt(n - 1);
         check(nrst == 0, "R5 no early expiry", nrst, 0);
         wt(1);
         check(reset_req == 1'b1, "R1 expiry pulse", reset_req, 1);
         check(wake_req == 1'b0, "R1 no wake when awake", wake_req, 0);
         check(timeout_n == 1'b0, "R8 flag low on expiry", timeout_n, 0);
         @(negedge clk);
         check(reset_req == 1'b0, "R1 single-cycle pulse", reset_req, 0);
         nrst = 0;
         wt(n - 1);
         check(nrst == 0, "R7 restart no early", nrst, 0);
         wt(1);
         check(reset_req == 1'b1, "R7 second expiry", reset_req, 1);
      end

      // R2: expiry while asleep
      ratio = 3'd0;
      sleep_mode = 1'b1;
      strobe(1'b1);
      check(timeout_n == 1'b1, "R8 sleep strobe sets flag", timeout_n, 1);
      wt(P - 1);
      check(nwake + nrst == 0, "R2 no early wake", nwake + nrst, 0);
      wt(1);
      check(wake_req == 1'b1, "R2 wake pulse", wake_req, 1);
      check(reset_req == 1'b0, "R2 no reset when asleep", reset_req, 0);
      sleep_mode = 1'b0;
      @(negedge clk);

      // R6: clear mid-count zeroes watchdog counter
      strobe(1'b0);
      wt(P - 1);
      strobe(1'b0);
      wt(P - 1);
      check(nrst == 0, "R6 counter cleared", nrst, 0);
      wt(1);
      check(reset_req == 1'b1, "R6 full period after clear", reset_req, 1);

      // R6: clear zeroes prescaler when owned by watchdog
      ratio = 3'd1;
      strobe(1'b0);
      wt(1);
      strobe(1'b0);
      wt(2*P - 1);
      check(nrst == 0, "R6 prescaler cleared", nrst, 0);
      wt(1);
      check(reset_req == 1'b1, "R6 expiry after prescaler clear", reset_req, 1);

      // R4: watchdog undivided when prescaler serves the timer
      psc_to_wdt = 1'b0;
      ratio = 3'd7;
      strobe(1'b0);
      wt(P - 1);
      check(nrst == 0, "R4 undivided no early", nrst, 0);
      wt(1);
      check(reset_req == 1'b1, "R4 undivided expiry", reset_req, 1);

      // R4 / R5: timer path sweep through the prescaler
      for (int r = 0; r < 8; r++) begin
         int d;
         d = 1 << r;
         psc_to_wdt = 1'b1;
         strobe(1'b0);
         psc_to_wdt = 1'b0;
         ratio = 3'(r);
         for (int i = 0; i < 3*d; i++) begin
            ttick(1'b1);
            check(tmr_tick == ((i % d) == d - 1), "R5 timer tap", tmr_tick,
                  int'((i % d) == d - 1));
         end
      end

      // R6: strobe leaves prescaler alone when it serves the timer
      psc_to_wdt = 1'b1;
      strobe(1'b0);
      psc_to_wdt = 1'b0;
      ratio = 3'd2;
      ttick(1'b1);
      ttick(1'b1);
      strobe(1'b0);
      ttick(1'b1);
      check(tmr_tick == 1'b0, "R6 timer prescaler kept (3rd)", tmr_tick, 0);
      ttick(1'b1);
      check(tmr_tick == 1'b1, "R6 timer prescaler kept (4th)", tmr_tick, 1);

      // R4: timer passthrough when prescaler serves the watchdog
      psc_to_wdt = 1'b1;
      ratio = 3'd5;
      ttick(1'b1); check(tmr_tick == 1'b1, "R4 passthrough", tmr_tick, 1);
      ttick(1'b1); check(tmr_tick == 1'b1, "R4 passthrough", tmr_tick, 1);
      ttick(1'b0); check(tmr_tick == 1'b0, "R4 passthrough", tmr_tick, 0);
      ttick(1'b1); check(tmr_tick == 1'b1, "R4 passthrough", tmr_tick, 1);

      // R3: disabled watchdog never counts
      ratio = 3'd0;
      strobe(1'b0);
      wdt_en = 1'b0;
      wt(3*P);
      check(nrst + nwake == 0, "R3 no request while disabled", nrst + nwake, 0);
      check(timeout_n == 1'b1, "R3 flag kept while disabled", timeout_n, 1);
      wdt_en = 1'b1;
      wt(P - 1);
      check(nrst == 0, "R3 count held while disabled", nrst, 0);
      wt(1);
      check(reset_req == 1'b1, "R3 expiry after enable", reset_req, 1);

      finish_run();
   end
endmodule